// File: doc/BRIEF.md
# Card Host Interrupt Status Register

This block gathers the event pulses and level signals produced around a memory-card host controller (command timing, data path, DMA engine, FIFO, boot-acknowledge detector) into one status word that software reads. It also raises a single interrupt line whenever any status bit selected by a programmable enable mask is set.

The bits follow three clear policies. Five event flags are sticky and clear after a status read. Two bits are live levels and follow their inputs in the same cycle. The overrun and underrun flags are sticky and are cleared by a new data-transfer command. When an error-clear mode bit is set, a status read also clears them. Writing 1 to that mode bit clears the underrun flag at once. A status read returns the values held before any clear, and a set event in the same cycle as any clear keeps the flag at 1.

Top module: `card_irq_status`

## Requirements
- R1: After synchronous reset, every sticky flag, the error-clear mode bit and the enable mask are 0, so with both level inputs low the status word is 0 and `irq` is 0.
- R2: Status word layout: bit 2 DMA done, bit 3 block overrun, bit 4 completion timeout, bit 5 boot acknowledge received, bit 6 boot acknowledge error. Each sets on the clock edge after its event pulse, holds, and clears on the edge that ends a cycle in which `stat_rd` is high.
- R3: While `stat_rd` is high, `stat_word` still shows the flag values from before the clear.
- R4: If a flag's set event and a clear happen in the same cycle, the flag is 1 after that edge.
- R5: Bit 0 equals `lvl_xfer_idle` and bit 1 equals `lvl_fifo_empty` in the same cycle, with no register in between.
- R6: Overrun (bit 7) sets on `evt_overrun` and clears on `new_xfer`. A status read does not clear it while the mode bit is 0.
- R7: While the mode bit (written by `cfg_wr` with `cfg_wdata`) is 1, a status read clears overrun. Writing the mode bit does not clear overrun.
- R8: Underrun (bit 8) sets on `evt_underrun`. It clears on `new_xfer` and on a `cfg_wr` with `cfg_wdata`=1. While the mode bit is 1, a status read also clears it. While the mode bit is 0, a status read leaves it set.
- R9: `irq` is high exactly when some bit of `stat_word` is 1 and the matching bit of the enable mask (written by `mask_wr` with `mask_wdata`) is 1. It follows the status word and mask in the same cycle.
- R10: An overrun event in the same cycle as `new_xfer` leaves overrun set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_cmpl_tmo | input | 1 | Completion-signal timeout expired (pulse) |
| evt_blk_ovr | input | 1 | New block arrived before DMA took the pending one (pulse) |
| evt_dma_done | input | 1 | DMA buffer transfer finished (pulse) |
| evt_boot_ack | input | 1 | Valid boot acknowledge detected (pulse) |
| evt_boot_err | input | 1 | Corrupted boot acknowledge detected (pulse) |
| evt_overrun | input | 1 | Received byte lost (pulse) |
| evt_underrun | input | 1 | Byte sent without written data (pulse) |
| lvl_fifo_empty | input | 1 | FIFO holds no bytes (level) |
| lvl_xfer_idle | input | 1 | Command path ready and data bus idle (level) |
| stat_rd | input | 1 | Status word read strobe |
| new_xfer | input | 1 | New data-transfer command issued (pulse) |
| cfg_wr | input | 1 | Write strobe for the error-clear mode bit |
| cfg_wdata | input | 1 | New error-clear mode bit value |
| mask_wr | input | 1 | Write strobe for the interrupt enable mask |
| mask_wdata | input | 9 | New interrupt enable mask |
| stat_word | output | 9 | Status word |
| irq | output | 1 | Masked interrupt request |

## Verification
Live bits and `irq` are combinational, so the bench checks them in the same cycle, shortly after it changes an input. Sticky flags and the mask change one edge after their strobe, so the bench drives each stimulus just after a rising edge and checks the result just after the next rising edge. The pre-clear read value is sampled while `stat_rd` is still high, before the edge that clears. Each clear is then checked one edge later.

// File: rtl/card_stat_pkg.sv
// Package: status word layout and counts shared by the status register block.
// Assumes live bits occupy the lowest positions and sticky bits follow in order.
package card_stat_pkg;
    localparam int STAT_W   = 9;
    localparam int N_LIVE   = 2;
    localparam int N_STICKY = STAT_W - N_LIVE;
    localparam int N_ROC    = 5;  // sticky bits cleared only by a status read

    // bit positions in the status word
    localparam int POS_XIDLE   = 0;
    localparam int POS_FEMPTY  = 1;
    localparam int POS_DMADONE = 2;
    localparam int POS_BLKOVR  = 3;
    localparam int POS_CTMO    = 4;
    localparam int POS_BACK    = 5;
    localparam int POS_BACKERR = 6;
    localparam int POS_OVR     = 7;
    localparam int POS_UNR     = 8;

    // indices into the sticky flag vector
    localparam int SIX_OVR = POS_OVR - N_LIVE;
    localparam int SIX_UNR = POS_UNR - N_LIVE;
endpackage

// File: rtl/sticky_flag_bank.sv
// Module: sticky_flag_bank
// A vector of set/clear flags. A set always beats a clear in the same cycle.
// Assumes set and clr are single-cycle strobes synchronous to clk.
module sticky_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    // Update every flag: set takes priority, otherwise clear, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= set | (q & ~clr);
    end

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[g] |=> q[g]); // R4
        AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] && !set[g]) |=> !q[g]); // R2
    end
endmodule

// File: rtl/err_clr_ctrl.sv
// Module: err_clr_ctrl
// Holds the error-clear mode bit and produces the clear strobes for the
// overrun and underrun flags. Assumes all strobes are one cycle wide.
module err_clr_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_wdata,
    input  logic stat_rd,
    input  logic new_xfer,
    output logic mode,
    output logic clr_ovr,
    output logic clr_unr
);
    // Capture the mode bit on a configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode <= 1'b0;
        else if (cfg_wr) mode <= cfg_wdata;
    end

    // Derive the clear strobes from the current mode and the strobes.
    always_comb begin
        clr_ovr = new_xfer | (mode & stat_rd);
        clr_unr = clr_ovr | (cfg_wr & cfg_wdata);
    end
endmodule

// File: rtl/irq_mask_gen.sv
// Module: irq_mask_gen
// Holds the interrupt enable mask and drives irq as the OR of the enabled
// status bits. Assumes the status word is stable for the whole cycle.
module irq_mask_gen #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_wr,
    input  logic [W-1:0] mask_wdata,
    input  logic [W-1:0] stat_word,
    output logic         irq
);
    logic [W-1:0] mask_q;

    // Load the enable mask on a mask write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= mask_wdata;
    end

    // Combine enabled status bits into one request.
    always_comb irq = |(stat_word & mask_q);

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat_word != '0)); // R9
endmodule

// File: rtl/card_irq_status.sv
// Module: card_irq_status (top)
// Status and error flag register of a memory-card host controller.
// Assumes event inputs are single-cycle pulses and the levels are synchronous.
module card_irq_status
    import card_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_cmpl_tmo,
    input  logic              evt_blk_ovr,
    input  logic              evt_dma_done,
    input  logic              evt_boot_ack,
    input  logic              evt_boot_err,
    input  logic              evt_overrun,
    input  logic              evt_underrun,
    input  logic              lvl_fifo_empty,
    input  logic              lvl_xfer_idle,
    input  logic              stat_rd,
    input  logic              new_xfer,
    input  logic              cfg_wr,
    input  logic              cfg_wdata,
    input  logic              mask_wr,
    input  logic [STAT_W-1:0] mask_wdata,
    output logic [STAT_W-1:0] stat_word,
    output logic              irq
);
    logic [N_STICKY-1:0] set_v;
    logic [N_STICKY-1:0] clr_v;
    logic [N_STICKY-1:0] flag_q;
    logic                mode;
    logic                clr_ovr;
    logic                clr_unr;

    // Route event pulses to their sticky flag slots.
    always_comb begin
        set_v                          = '0;
        set_v[POS_DMADONE - N_LIVE]    = evt_dma_done;
        set_v[POS_BLKOVR - N_LIVE]     = evt_blk_ovr;
        set_v[POS_CTMO - N_LIVE]       = evt_cmpl_tmo;
        set_v[POS_BACK - N_LIVE]       = evt_boot_ack;
        set_v[POS_BACKERR - N_LIVE]    = evt_boot_err;
        set_v[SIX_OVR]                 = evt_overrun;
        set_v[SIX_UNR]                 = evt_underrun;
    end

    // Pick each flag's clear source: read for the plain ones, policy for the rest.
    always_comb begin
        for (int k = 0; k < N_STICKY; k++) clr_v[k] = (k < N_ROC) ? stat_rd : 1'b0;
        clr_v[SIX_OVR] = clr_ovr;
        clr_v[SIX_UNR] = clr_unr;
    end

    err_clr_ctrl u_clr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_wdata(cfg_wdata),
        .stat_rd  (stat_rd),
        .new_xfer (new_xfer),
        .mode     (mode),
        .clr_ovr  (clr_ovr),
        .clr_unr  (clr_unr)
    );

    sticky_flag_bank #(.N(N_STICKY)) u_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (set_v),
        .clr  (clr_v),
        .q    (flag_q)
    );

    // Assemble the status word: sticky flags above the live levels.
    always_comb begin
        stat_word             = {flag_q, {N_LIVE{1'b0}}};
        stat_word[POS_XIDLE]  = lvl_xfer_idle;
        stat_word[POS_FEMPTY] = lvl_fifo_empty;
    end

    irq_mask_gen #(.W(STAT_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_wr   (mask_wr),
        .mask_wdata(mask_wdata),
        .stat_word (stat_word),
        .irq       (irq)
    );

    AST_OVR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[POS_OVR] && stat_rd && !mode && !new_xfer) |=> stat_word[POS_OVR]); // R6
    AST_OVR_ROC: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && mode && !evt_overrun) |=> !stat_word[POS_OVR]); // R7
    AST_UNR_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata && !evt_underrun) |=> !stat_word[POS_UNR]); // R8
    AST_OVR_NEWCMD: assert property (@(posedge clk) disable iff (!rst_n)
        (new_xfer && evt_overrun) |=> stat_word[POS_OVR]); // R10
endmodule

// File: tb/tb_card_irq_status.sv
module tb_card_irq_status;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       evt_cmpl_tmo, evt_blk_ovr, evt_dma_done, evt_boot_ack, evt_boot_err;
    logic       evt_overrun, evt_underrun, lvl_fifo_empty, lvl_xfer_idle;
    logic       stat_rd, new_xfer, cfg_wr, cfg_wdata, mask_wr;
    logic [8:0] mask_wdata;
    logic [8:0] stat_word;
    logic       irq;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done  = 0;

    always #10 clk = ~clk;  // 50 MHz

    card_irq_status dut (.*);

    // Advance one rising edge, then settle just past it.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_all();
        {evt_cmpl_tmo, evt_blk_ovr, evt_dma_done, evt_boot_ack, evt_boot_err} = '0;
        {evt_overrun, evt_underrun, lvl_fifo_empty, lvl_xfer_idle} = '0;
        {stat_rd, new_xfer, cfg_wr, cfg_wdata, mask_wr} = '0;
        mask_wdata = '0;
    endtask

    task automatic do_read();
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
    endtask

    task automatic wr_mode(logic v);
        cfg_wr = 1'b1; cfg_wdata = v; tick(); cfg_wr = 1'b0; cfg_wdata = 1'b0;
    endtask

    task automatic wr_mask(logic [8:0] m);
        mask_wr = 1'b1; mask_wdata = m; tick(); mask_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 status after reset", stat_word, 9'h000);
        chk("R1 irq after reset", irq, 1'b0);
        lvl_fifo_empty = 1'b1; lvl_xfer_idle = 1'b1; #1;
        chk("R1 mask zero keeps irq low", irq, 1'b0);
        lvl_fifo_empty = 1'b0; lvl_xfer_idle = 1'b0; #1;
    endtask

    task automatic t_live();
        lvl_fifo_empty = 1'b1; #1;
        chk("R5 fifo empty live", stat_word, 9'h002);
        lvl_xfer_idle = 1'b1; #1;
        chk("R5 both live", stat_word, 9'h003);
        lvl_fifo_empty = 1'b0; #1;
        chk("R5 fifo empty drop", stat_word, 9'h001);
        lvl_xfer_idle = 1'b0; #1;
        chk("R5 idle drop", stat_word, 9'h000);
    endtask

    task automatic t_sticky();
        evt_dma_done = 1'b1; tick(); evt_dma_done = 1'b0;
        chk("R2 dma done set", stat_word, 9'h004);
        evt_blk_ovr = 1'b1; evt_cmpl_tmo = 1'b1; tick();
        evt_blk_ovr = 1'b0; evt_cmpl_tmo = 1'b0;
        evt_boot_ack = 1'b1; evt_boot_err = 1'b1; tick();
        evt_boot_ack = 1'b0; evt_boot_err = 1'b0;
        tick(); tick();
        chk("R2 five flags held", stat_word, 9'h07C);
        stat_rd = 1'b1; #1;
        chk("R3 read shows pre-clear", stat_word, 9'h07C);
        tick(); stat_rd = 1'b0;
        chk("R2 cleared after read", stat_word, 9'h000);
    endtask

    task automatic t_set_wins();
        evt_boot_ack = 1'b1; tick(); evt_boot_ack = 1'b0;
        stat_rd = 1'b1; evt_boot_ack = 1'b1; tick();
        stat_rd = 1'b0; evt_boot_ack = 1'b0;
        chk("R4 set beats read clear", stat_word, 9'h020);
        do_read();
        chk("R4 later read clears", stat_word, 9'h000);
    endtask

    task automatic t_overrun();
        evt_overrun = 1'b1; tick(); evt_overrun = 1'b0;
        chk("R6 overrun set", stat_word, 9'h080);
        do_read();
        chk("R6 read keeps overrun in mode 0", stat_word, 9'h080);
        new_xfer = 1'b1; tick(); new_xfer = 1'b0;
        chk("R6 new command clears overrun", stat_word, 9'h000);
        new_xfer = 1'b1; evt_overrun = 1'b1; tick();
        new_xfer = 1'b0; evt_overrun = 1'b0;
        chk("R10 overrun survives same-cycle command", stat_word, 9'h080);
        wr_mode(1'b1);
        chk("R7 mode write keeps overrun", stat_word, 9'h080);
        do_read();
        chk("R7 read clears overrun in mode 1", stat_word, 9'h000);
        wr_mode(1'b0);
    endtask

    task automatic t_underrun();
        evt_underrun = 1'b1; tick(); evt_underrun = 1'b0;
        chk("R8 underrun set", stat_word, 9'h100);
        do_read();
        chk("R8 read keeps underrun in mode 0", stat_word, 9'h100);
        wr_mode(1'b1);
        chk("R8 mode write of 1 clears underrun", stat_word, 9'h000);
        evt_underrun = 1'b1; tick(); evt_underrun = 1'b0;
        do_read();
        chk("R8 read clears underrun in mode 1", stat_word, 9'h000);
        wr_mode(1'b0);
        evt_underrun = 1'b1; tick(); evt_underrun = 1'b0;
        wr_mode(1'b0);
        chk("R8 mode write of 0 keeps underrun", stat_word, 9'h100);
        new_xfer = 1'b1; tick(); new_xfer = 1'b0;
        chk("R8 new command clears underrun", stat_word, 9'h000);
    endtask

    task automatic t_irq();
        evt_dma_done = 1'b1; tick(); evt_dma_done = 1'b0;
        chk("R9 flag without mask", irq, 1'b0);
        wr_mask(9'h004);
        chk("R9 enabled flag raises irq", irq, 1'b1);
        wr_mask(9'h008);
        chk("R9 other bit enabled only", irq, 1'b0);
        wr_mask(9'h00A);
        lvl_fifo_empty = 1'b1; #1;
        chk("R9 live bit raises irq", irq, 1'b1);
        lvl_fifo_empty = 1'b0; #1;
        chk("R9 live bit drop lowers irq", irq, 1'b0);
        wr_mask(9'h004);
        do_read();
        chk("R9 irq drops after flag clears", irq, 1'b0);
    endtask

    initial begin
        idle_all();
        rst_n = 1'b0;
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_live();
        t_sticky();
        t_set_wins();
        t_overrun();
        t_underrun();
        t_irq();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule